// File: doc/BRIEF.md
# DMA Bus Hold Limiter

This block limits how long a high-priority DMA channel may keep the system bus during one burst. Software writes an 8-bit control word: the top bit turns the limiter on, and the low seven bits give the hold budget in units of 256 system clocks. The DMA engine raises `dma_active` while it owns the bus. While that flag stays high, a 256-clock prescaler and a unit counter measure the time the bus has been held. When the held time reaches the budget, the block issues a one-cycle `term_req` pulse so that the engine gives the bus back to the CPU.

The configuration is captured when a burst starts. Writes made while a burst is running take effect from the next burst. A budget of zero is not valid. Writing a zero budget leaves the stored budget as it was and raises `cfg_err`. Dropping `dma_active` clears the counters, so every burst starts with the full budget.

Top module: `dma_hold_limiter`

## Requirements
- R1: After reset, `cfg_rdata` is 0x00, `cfg_err` is 0 and `term_req` is 0.
- R2: A write sets the enable bit from bit 7 of `cfg_wdata` and the budget from bits 6:0. `cfg_rdata` shows the stored value, with the enable bit in bit 7 and the budget in bits 6:0.
- R3: With the limiter enabled and a budget L, counting from the first rising edge at which `dma_active` is sampled high, `term_req` is high for exactly the cycle that follows edge number L×256. This holds while `dma_active` stays high throughout.
- R4: Within one burst `term_req` pulses at most once, even if the burst runs far beyond the budget.
- R5: A burst that ends before its budget runs out produces no `term_req`. The next burst again gets the full budget of L×256 edges.
- R6: When the enable bit captured at the start of a burst is 0, that burst produces no `term_req`.
- R7: A write whose bits 6:0 are zero leaves the stored budget unchanged, still updates the enable bit, and sets `cfg_err` to 1. A later write with a nonzero budget clears `cfg_err`. A stored budget of 0, which is the value after reset, never produces `term_req`.
- R8: Changing the configuration while `dma_active` is high does not affect the running burst. The new value applies from the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 8 | Control word: bit 7 enable, bits 6:0 budget in 256-clock units |
| cfg_rdata | output | 8 | Stored control word |
| cfg_err | output | 1 | Set when a zero budget was written |
| dma_active | input | 1 | High while the DMA engine holds the bus |
| term_req | output | 1 | One-cycle forced-termination request |

## Verification
The assertions assume that `dma_active` is a clean level which changes only between clock edges. They also assume that `term_req` may go unanswered, so the burst may stay high after the pulse. The stimulus therefore drives every input at the falling edge and keeps some bursts running well past expiry. It checks each pulse position arithmetically against L×256 for every budget from 1 to 8 and for 127. Readback and error behaviour are swept over all 256 control words, with the expected value tracked in the bench.

// File: rtl/dma_hold_limiter.sv
module dma_hold_limiter #(
  parameter int PRE_W = 8,
  parameter int LIM_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [LIM_W:0]   cfg_wdata,
  output logic [LIM_W:0]   cfg_rdata,
  output logic             cfg_err,
  input  logic             dma_active,
  output logic             term_req
);
  localparam logic [PRE_W-1:0] PRE_MAX = '1;

  logic             en_q, snap_en, fired_q, term_q, err_q;
  logic [LIM_W-1:0] lim_q, snap_lim, units_q;
  logic [PRE_W-1:0] pre_q;
  logic             wr_zero, hit;

  assign wr_zero   = cfg_wr && (cfg_wdata[LIM_W-1:0] == '0);
  assign cfg_rdata = {en_q, lim_q};
  assign cfg_err   = err_q;
  assign term_req  = term_q;

  assign hit = dma_active && snap_en && (snap_lim != '0) && !fired_q &&
               (pre_q == PRE_MAX) &&
               (({1'b0, units_q} + 1'b1) == {1'b0, snap_lim});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      lim_q <= '0;
      err_q <= 1'b0;
    end else if (cfg_wr) begin
      en_q  <= cfg_wdata[LIM_W];
      err_q <= wr_zero;
      if (!wr_zero) lim_q <= cfg_wdata[LIM_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_en  <= 1'b0;
      snap_lim <= '0;
    end else if (!dma_active) begin
      snap_en  <= en_q;
      snap_lim <= lim_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      units_q <= '0;
      fired_q <= 1'b0;
      term_q  <= 1'b0;
    end else begin
      term_q <= hit;
      if (!dma_active) begin
        pre_q   <= '0;
        units_q <= '0;
        fired_q <= 1'b0;
      end else if (!fired_q) begin
        pre_q <= pre_q + 1'b1;
        if (pre_q == PRE_MAX) units_q <= units_q + 1'b1;
        if (hit) fired_q <= 1'b1;
      end
    end
  end

  // R4
  term_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_req |=> !term_req);

  // R5
  term_needs_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_active |=> !term_req);

  // R6
  term_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_en |=> !term_req);

  // R7
  zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_zero |=> ($stable(cfg_rdata[LIM_W-1:0]) && cfg_err));

  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_active |=> $stable({snap_en, snap_lim}));
endmodule

// File: tb/dma_hold_limiter_bench.sv
module dma_hold_limiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int UNIT = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       cfg_err;
  logic       dma_active = 1'b0;
  logic       term_req;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_hold_limiter u_dma_hold_limiter (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_err(cfg_err), .dma_active(dma_active),
    .term_req(term_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Runs a burst of len edges; exp_at = 0 means no pulse expected.
  // mid_at > 0 performs a write of mid_v during the burst at that edge.
  task automatic run_burst(input string req, input int len, input int exp_at,
                           input int mid_at, input logic [7:0] mid_v);
    int pulses = 0;
    int first = 0;
    @(negedge clk);
    dma_active = 1'b1;
    for (int k = 1; k <= len; k++) begin
      cfg_wr = (k == mid_at);
      if (k == mid_at) cfg_wdata = mid_v;
      @(negedge clk);
      if (term_req) begin
        pulses++;
        if (first == 0) first = k;
      end
    end
    cfg_wr = 1'b0;
    dma_active = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check({req, " pulse count"}, pulses, (exp_at != 0) ? 1 : 0);
    check({req, " pulse edge"}, first, exp_at);
  endtask

  initial begin
    logic [7:0] model;
    int lim;
    #(3*CLK_PERIOD + 2);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", cfg_rdata, 0);
    check("R1 err", cfg_err, 0);
    check("R1 term", term_req, 0);

    // R7 stored budget zero after reset, enable only
    write_cfg(8'h80);
    check("R7 err on zero", cfg_err, 1);
    run_burst("R7 zero budget", 600, 0, 0, 8'h00);

    // R2 R7 exhaustive readback sweep
    model = 8'h80;
    for (int v = 0; v < 256; v++) begin
      write_cfg(v[7:0]);
      if (v[6:0] != 0) model = v[7:0];
      else model = {v[7], model[6:0]};
      check($sformatf("R2 readback v=%0d", v), cfg_rdata, model);
      check($sformatf("R7 err v=%0d", v), cfg_err, (v[6:0] == 0) ? 1 : 0);
    end

    // R3 R4 budgets 1..8 and 127, bursts extended past expiry
    for (int l = 1; l <= 8; l++) begin
      write_cfg(8'h80 | l[7:0]);
      run_burst($sformatf("R3 R4 L=%0d", l), l*UNIT + 300, l*UNIT, 0, 8'h00);
    end
    write_cfg(8'hFF);
    run_burst("R3 L=127", 127*UNIT + 10, 127*UNIT, 0, 8'h00);
    write_cfg(8'h87);
    check("R2 0x87 readback", cfg_rdata, 8'h87);
    run_burst("R3 R4 0x87", 7*UNIT + 600, 1792, 0, 8'h00);

    // R5 early end then full budget
    write_cfg(8'h82);
    run_burst("R5 early", 2*UNIT - 1, 0, 0, 8'h00);
    run_burst("R5 short", 300, 0, 0, 8'h00);
    run_burst("R5 fresh", 2*UNIT + 20, 2*UNIT, 0, 8'h00);

    // R6 disabled
    write_cfg(8'h01);
    run_burst("R6 disabled", 3*UNIT, 0, 0, 8'h00);

    // R8 mid-burst changes
    write_cfg(8'h82);
    run_burst("R8 shrink mid", 2*UNIT + 20, 2*UNIT, 10, 8'h81);
    lim = 1;
    run_burst("R8 next burst", 3*UNIT, lim*UNIT, 0, 8'h00);
    run_burst("R8 disable mid", 2*UNIT, UNIT, 5, 8'h01);
    run_burst("R8 disabled next", 2*UNIT, 0, 8, 8'h83);
    run_burst("R8 enable next", 4*UNIT, 3*UNIT, 0, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule